// File: doc/BRIEF.md
# Low-Transition Scan Pattern Generator

This block is a self-test pattern source for one scan chain. A 16-bit maximal-length linear feedback shift register produces pseudo-random state. A small group of its bits is combined by an AND. The AND result is the toggle input of a toggle flip-flop, and the output of that flip-flop is the scan-in bit. The scan value therefore changes only when every selected bit is 1. Neighbouring bits in the chain are strongly correlated, so far fewer transitions occur while shifting than when the register is fed straight into the chain.

A control part counts shift cycles. It holds scan-enable high for a programmable run length and then drops it for one capture cycle, during which it pulses pattern-done. A seed load restarts the register from a chosen value at any time.

Top module: `lowtrans_scan_gen`

## Requirements
- R1: While reset is active and right after it, scanIn, scanEnable and patternDone are 0. The register state is 16'h0001.
- R2: On each shift cycle the register state s advances to {s[14:0], s[15]^s[14]^s[12]^s[3]}, which is the polynomial x^16+x^15+x^13+x^4+1. The state is never zero.
- R3: A cycle with seedLoad high loads seedValue into the register, or 16'h0001 when seedValue is zero. The same cycle clears the toggle flip-flop to 0, restarts the shift count and leaves capture. seedLoad takes priority over enable, and scanEnable and patternDone are 0 in that cycle.
- R4: On each shift cycle the toggle flip-flop takes its old value XOR the AND of the first TAPS bits of the list s[0], s[4], s[8], s[12]. These bits are taken from the state before it advances. scanIn is the flip-flop output.
- R5: When that AND is 0 on a shift cycle, scanIn keeps its value.
- R6: With enable held high, scanEnable is 1 for max(runLength,1) consecutive cycles. It is then 0 for one capture cycle, in which patternDone is 1, and the sequence repeats. The register and the flip-flop do not change in the capture cycle.
- R7: While enable is low and seedLoad is low, nothing advances. scanEnable and patternDone are 0.
- R8: With TAPS = 1, scanIn is the running XOR of bit s[0] over the shift cycles.
- R9: Over a long run with TAPS = 3, scanIn has fewer transitions across shift cycles than bit s[0] of the register has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Lets shift and capture cycles proceed |
| seedLoad | input | 1 | Loads seedValue and restarts the pattern |
| seedValue | input | 16 | Seed for the register |
| runLength | input | CNT_W | Number of shift cycles per pattern (0 acts as 1) |
| scanIn | output | 1 | Serial data for the scan chain |
| scanEnable | output | 1 | High during shift cycles |
| patternDone | output | 1 | One-cycle strobe in the capture cycle |

## Verification
The bench builds two copies of the block that share the same inputs. One uses TAPS = 3 and the other TAPS = 1, both with CNT_W = 8. The three-tap copy makes the hold behaviour frequent and allows the transition count to be compared against the plain register bit. The one-tap copy exposes the running-XOR case. With 8-bit run lengths, both the degenerate lengths 0 and 1 and long patterns are reached. Random seed reloads in mid-pattern exercise the priority of seedLoad over enable.

// File: rtl/ltsg_pkg.sv
package ltsg_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] RESET_STATE = 16'h0001;

  typedef struct packed {
    logic advance;
    logic reload;
  } ltsgStrobe_t;

  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

endpackage

// File: rtl/ltsg_datapath.sv
module ltsg_datapath
  import ltsg_pkg::*;
#(
  parameter int TAPS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ltsgStrobe_t       strobe,
  input  logic [LFSR_W-1:0] seedValue,
  output logic              scanBit
);

  localparam int TAP_N = (TAPS < 1) ? 1 : ((TAPS > 4) ? 4 : TAPS);

  logic [LFSR_W-1:0] lfsrQ;
  logic [TAP_N-1:0]  tapVec;
  logic              andOut;
  logic              tffQ;

  genvar gi;
  generate
    for (gi = 0; gi < TAP_N; gi++) begin : g_tap
      assign tapVec[gi] = lfsrQ[gi*4];
    end
  endgenerate

  assign andOut = &tapVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrQ <= RESET_STATE;
      tffQ  <= 1'b0;
    end else if (strobe.reload) begin
      lfsrQ <= (seedValue == '0) ? RESET_STATE : seedValue;
      tffQ  <= 1'b0;
    end else if (strobe.advance) begin
      lfsrQ <= lfsrStep(lfsrQ);
      tffQ  <= tffQ ^ andOut;
    end
  end

  assign scanBit = tffQ;

  a_r2_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  a_r3_zero_seed: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload && seedValue == '0 |=> lfsrQ == RESET_STATE);

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !strobe.reload && andOut |=> scanBit != $past(scanBit));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && !strobe.reload && !andOut |=> $stable(scanBit));

  a_r6_capture_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance && !strobe.reload |=> $stable(lfsrQ) && $stable(scanBit));

endmodule

// File: rtl/ltsg_control.sv
module ltsg_control
  import ltsg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             seedLoad,
  input  logic [CNT_W-1:0] runLength,
  output ltsgStrobe_t      strobe,
  output logic             scanEnable,
  output logic             patternDone
);

  logic [CNT_W-1:0] shiftCnt;
  logic [CNT_W-1:0] lenEff;
  logic             inCapture;
  logic             lastShift;

  assign lenEff    = (runLength == '0) ? CNT_W'(1) : runLength;
  assign lastShift = (shiftCnt + CNT_W'(1)) >= lenEff || shiftCnt == '1;

  assign scanEnable     = enable && !seedLoad && !inCapture;
  assign patternDone    = enable && !seedLoad && inCapture;
  assign strobe.advance = scanEnable;
  assign strobe.reload  = seedLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftCnt  <= '0;
      inCapture <= 1'b0;
    end else if (seedLoad) begin
      shiftCnt  <= '0;
      inCapture <= 1'b0;
    end else if (enable) begin
      if (inCapture) begin
        inCapture <= 1'b0;
      end else if (lastShift) begin
        shiftCnt  <= '0;
        inCapture <= 1'b1;
      end else begin
        shiftCnt <= shiftCnt + CNT_W'(1);
      end
    end
  end

  a_r3_restart: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> shiftCnt == '0 && !inCapture);

  a_r6_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    patternDone |=> !patternDone);

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(patternDone && scanEnable));

  a_r7_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !enable && !seedLoad |=> $stable(shiftCnt) && $stable(inCapture));

endmodule

// File: rtl/lowtrans_scan_gen.sv
module lowtrans_scan_gen
  import ltsg_pkg::*;
#(
  parameter int TAPS  = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             seedLoad,
  input  logic [15:0]      seedValue,
  input  logic [CNT_W-1:0] runLength,
  output logic             scanIn,
  output logic             scanEnable,
  output logic             patternDone
);

  ltsgStrobe_t strobe;

  ltsg_control #(.CNT_W(CNT_W)) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .seedLoad    (seedLoad),
    .runLength   (runLength),
    .strobe      (strobe),
    .scanEnable  (scanEnable),
    .patternDone (patternDone)
  );

  ltsg_datapath #(.TAPS(TAPS)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .seedValue (seedValue),
    .scanBit   (scanIn)
  );

endmodule

// File: tb/test_lowtrans_scan_gen.sv
module test_lowtrans_scan_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       seedLoad = 1'b0;
  logic [15:0] seedValue = '0;
  logic [7:0] runLength = 8'd4;
  logic       scanIn3, scanEnable3, patternDone3;
  logic       scanIn1, scanEnable1, patternDone1;

  always #5 clk = ~clk;

  lowtrans_scan_gen #(.TAPS(3), .CNT_W(8)) i_lowtrans_scan_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .seedLoad(seedLoad),
    .seedValue(seedValue), .runLength(runLength),
    .scanIn(scanIn3), .scanEnable(scanEnable3), .patternDone(patternDone3));

  lowtrans_scan_gen #(.TAPS(1), .CNT_W(8)) i_lowtrans_scan_gen_k1 (
    .clk(clk), .rstN(rstN), .enable(enable), .seedLoad(seedLoad),
    .seedValue(seedValue), .runLength(runLength),
    .scanIn(scanIn1), .scanEnable(scanEnable1), .patternDone(patternDone1));

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [15:0] mL;
  logic        mT3, mT1, mCap;
  int          mCnt;

  bit counting = 1'b0;
  int txDut, txDirect;
  logic prevDut, prevDirect;
  bit havePrev;

  function automatic logic [15:0] refStep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input logic en, input logic ld, input logic [15:0] sv,
                      input logic [7:0] rl, input string tag);
    logic expSe, expPd;
    int lenEff;
    @(negedge clk);
    enable = en; seedLoad = ld; seedValue = sv; runLength = rl;
    #1;
    expSe = en && !ld && !mCap;
    expPd = en && !ld && mCap;
    chk(scanIn3 == mT3, tag, "scanIn taps3", int'(scanIn3), int'(mT3));
    chk(scanIn1 == mT1, "R8", "scanIn taps1", int'(scanIn1), int'(mT1));
    chk(scanEnable3 == expSe, tag, "scanEnable", int'(scanEnable3), int'(expSe));
    chk(patternDone3 == expPd, tag, "patternDone", int'(patternDone3), int'(expPd));
    if (counting && expSe) begin
      if (havePrev) begin
        if (scanIn3 != prevDut) txDut++;
        if (mL[0] != prevDirect) txDirect++;
      end
      prevDut = scanIn3; prevDirect = mL[0]; havePrev = 1'b1;
    end
    lenEff = (rl == 0) ? 1 : int'(rl);
    if (ld) begin
      mL = (sv == 0) ? 16'h0001 : sv;
      mT3 = 1'b0; mT1 = 1'b0; mCnt = 0; mCap = 1'b0;
    end else if (en) begin
      if (mCap) mCap = 1'b0;
      else begin
        mT3 = mT3 ^ (mL[0] & mL[4] & mL[8]);
        mT1 = mT1 ^ mL[0];
        mL = refStep(mL);
        if (mCnt + 1 >= lenEff) begin mCnt = 0; mCap = 1'b1; end
        else mCnt++;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mL = 16'h0001; mT3 = 1'b0; mT1 = 1'b0; mCap = 1'b0; mCnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(scanIn3 == 1'b0, "R1", "scanIn in reset", int'(scanIn3), 0);
    chk(scanEnable3 == 1'b0, "R1", "scanEnable in reset", int'(scanEnable3), 0);
    chk(patternDone3 == 1'b0, "R1", "patternDone in reset", int'(patternDone3), 0);
    rstN = 1'b1;

    // R7: idle, nothing moves
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 16'h0, 8'd3, "R7");
    // R1/R2: run from reset state 1
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 16'h0, 8'd4, "R1 R2 R4 R6");
    // R3: zero seed becomes 1
    tick(1'b1, 1'b1, 16'h0000, 8'd5, "R3");
    for (int i = 0; i < 25; i++) tick(1'b1, 1'b0, 16'h0, 8'd5, "R3 R4 R5 R6");
    // R6: run length zero acts as one
    tick(1'b1, 1'b1, 16'hFFFF, 8'd0, "R3");
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, 16'h0, 8'd0, "R6");
    // R3: reload in the middle, with enable high
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 16'h0, 8'd9, "R6");
    tick(1'b1, 1'b1, 16'h1111, 8'd9, "R3");
    for (int i = 0; i < 12; i++) tick(1'b1, 1'b0, 16'h0, 8'd9, "R3 R5 R6");
    // R7: pause in mid-pattern
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 16'h0, 8'd9, "R7");
    for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, 16'h0, 8'd9, "R6 R7");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic en, ld;
      logic [15:0] sv;
      logic [7:0] rl;
      en = ($urandom % 8) != 0;
      ld = ($urandom % 150) == 0;
      sv = (($urandom % 4) == 0) ? 16'h0 : 16'($urandom);
      rl = (i % 300 < 150) ? 8'd7 : 8'd33;
      tick(en, ld, sv, rl, "R2 R4 R5 R6 R7");
    end

    // R9: transition comparison
    tick(1'b1, 1'b1, 16'hACE1, 8'd64, "R3");
    counting = 1'b1; txDut = 0; txDirect = 0; havePrev = 1'b0;
    for (int i = 0; i < 3000; i++) tick(1'b1, 1'b0, 16'h0, 8'd64, "R4 R9");
    counting = 1'b0;
    chk(txDut < txDirect, "R9", "scanIn transitions vs direct", txDut, txDirect);
    chk(txDut > 0, "R9", "scanIn transitions nonzero", txDut, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule